// File: doc/BRIEF.md
# BCD calendar clock with hundredths

This block is a timekeeping core that counts time and date directly in binary-coded decimal. A 100 Hz enable pulse drives it, and each advance moves the hundredths of a second forward. Carries ripple through seconds, minutes, hours, day of week, date, month and a two-digit year. Eight 8-bit registers hold the state, and they are always visible together as one 64-bit snapshot. A serial front end, which is not part of this block, takes that snapshot when it reads the time. When it writes the time, it applies all eight registers in a single parallel load.

The hours register carries its own format control: a 12/24-hour mode bit and, in 12-hour mode, a PM flag. The day register holds two control bits. One stops the clock. The other is an enable for an external abort pin and is presented as an output for the serial front end to use. February takes 29 days when the year value is a multiple of four. No century rule is applied.

A parameter sets how many enable pulses make one hundredth of a second, so a faster reference can also drive the core.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the snapshot reads, from byte 0 (bits 7:0) to byte 7 (bits 63:56): hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day 0x31 (stop bit 5 = 1, abort enable bit 4 = 1, weekday 1), date 0x01, month 0x01, year 0x00.
- R2: A load stores `load_data` ANDed with the per-byte mask 0xFF (hundredths), 0x7F (seconds), 0x7F (minutes), 0xBF (hours), 0x37 (day), 0x3F (date), 0x1F (month) and 0xFF (year). Masked-off bits always read back as 0.
- R3: A load in the same cycle as a tick takes priority: the loaded value appears and the tick is lost. A load also restarts the tick prescaler.
- R4: Hundredths count 00..99 in BCD, and seconds and minutes count 00..59. Each wraps to 00 and carries into the next field.
- R5: In 24-hour mode (hours bit 7 = 0), hours count 00..23 in BCD, with bit 5 acting as the tens-of-twenty bit. The step from 23 to 00 carries into the day.
- R6: In 12-hour mode (hours bit 7 = 1), bits 4:0 count 12, 01, 02 … 11. Bit 5 is PM (1 = PM) and toggles on the step from 11 to 12. The step from 11 PM to 12 AM carries into the day.
- R7: The weekday (day bits 2:0) counts 1..7 and wraps to 1 on a day carry.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. On wrap the month advances.
- R9: In February the date wraps after 29 when the year value is divisible by 4, and after 28 otherwise.
- R10: The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R11: While day bit 5 is 1, ticks are ignored and the snapshot holds. While it is 0, time advances.
- R12: Output `abort_pin_en` always equals day register bit 4.
- R13: The hundredths advance once per `TICKS_PER_STEP` tick pulses counted while the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle time-base enable pulse |
| load_en | input | 1 | Parallel load strobe for all eight registers |
| load_data | input | 64 | Load value, byte 0 = hundredths … byte 7 = year |
| snap | output | 64 | Current register contents, same byte order |
| abort_pin_en | output | 1 | Day register bit 4 |

## Verification
The bench builds the core with `TICKS_PER_STEP` = 2 and two reset synchronizer stages. This selects the counting variant of the prescaler, so the bench can check tick phases, a prescaler restart on load, and ticks that fall on idle cycles. The bench reaches each rollover by loading the state just before it: every month end, leap and common Februaries, the 12-hour transitions and the full year rollover. A long pseudo-random tick stream then covers ordinary carries.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_REG = 8;
  localparam int BUS_W   = REG_W * NUM_REG;

  typedef struct packed {
    logic [REG_W-1:0] year;
    logic [REG_W-1:0] month;
    logic [REG_W-1:0] date;
    logic [REG_W-1:0] day;
    logic [REG_W-1:0] hours;
    logic [REG_W-1:0] mins;
    logic [REG_W-1:0] secs;
    logic [REG_W-1:0] hund;
  } cal_regs_t;

  localparam logic [BUS_W-1:0] FIELD_MASK = 64'hFF1F_3F37_BF7F_7FFF;
  localparam logic [BUS_W-1:0] RESET_VAL  = 64'h0001_0131_0000_0000;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    int yv;
    yv = int'(yr[7:4]) * 10 + int'(yr[3:0]);
    case (mon)
      8'h02:                      return ((yv % 4) == 0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_tick_gate.sv
module cal_tick_gate #(
  parameter int TICKS_PER_STEP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic step
);
  localparam int CW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);

  generate
    if (TICKS_PER_STEP == 1) begin : g_direct
      assign step = tick & run & ~clr;
    end else begin : g_div
      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = clr | (tick & run);
        if (clr || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign step = tick & run & ~clr & (cnt_q == LAST);
    end
  endgenerate

  // R13
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick && run && !clr));
endmodule

// File: rtl/cal_wrap_cnt.sv
module cal_wrap_cnt
  import cal_pkg::*;
#(
  parameter int           W     = 8,
  parameter logic [W-1:0] LIMIT = '0,
  parameter logic [W-1:0] START = '0
) (
  input  logic [W-1:0] val,
  input  logic         en,
  output logic [W-1:0] nxt,
  output logic         carry
);
  always_comb begin
    carry = en & (val == LIMIT);
    if (!en)                nxt = val;
    else if (val == LIMIT)  nxt = START;
    else                    nxt = W'(bcd_inc(8'(val)));
  end
endmodule

// File: rtl/cal_hours_step.sv
module cal_hours_step
  import cal_pkg::*;
(
  input  logic [7:0] hr,
  input  logic       en,
  output logic [7:0] nxt,
  output logic       carry
);
  logic       mode12, pm;
  logic [5:0] h12;
  logic [6:0] h24;
  logic [7:0] inc12, inc24;

  always_comb begin
    mode12 = hr[7];
    pm     = hr[5];
    h12    = {hr[6], hr[4:0]};
    h24    = hr[6:0];
    inc12  = bcd_inc({2'b00, h12});
    inc24  = bcd_inc({1'b0, h24});
    carry  = 1'b0;
    nxt    = hr;
    if (en) begin
      if (mode12) begin
        if (h12 == 6'h11) begin
          nxt   = {2'b10, ~pm, 5'h12};
          carry = pm;
        end else if (h12 == 6'h12) begin
          nxt = {2'b10, pm, 5'h01};
        end else begin
          nxt = {2'b10, pm, inc12[4:0]};
        end
      end else if (h24 == 7'h23) begin
        nxt   = 8'h00;
        carry = 1'b1;
      end else begin
        nxt = {2'b00, inc24[5:0]};
      end
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int TICKS_PER_STEP  = 1,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [BUS_W-1:0] load_data,
  output logic [BUS_W-1:0] snap,
  output logic             abort_pin_en
);
  localparam int NTM = 3;

  logic [RST_SYNC_STAGES-1:0] sync_q;
  logic rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ok = sync_q[RST_SYNC_STAGES-1];

  cal_regs_t q, d;
  logic      step, upd;

  cal_tick_gate #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_gate (
    .clk(clk), .rst_n(rst_ok), .tick(tick), .run(~q.day[5]), .clr(load_en), .step(step)
  );

  logic [7:0] tm_val [NTM];
  logic [7:0] tm_nxt [NTM];
  logic       tm_en  [NTM+1];

  assign tm_val[0] = q.hund;
  assign tm_val[1] = q.secs;
  assign tm_val[2] = q.mins;
  assign tm_en[0]  = step;

  generate
    for (genvar g = 0; g < NTM; g++) begin : g_tm
      cal_wrap_cnt #(.W(8), .LIMIT((g == 0) ? 8'h99 : 8'h59), .START(8'h00)) u_cnt (
        .val(tm_val[g]), .en(tm_en[g]), .nxt(tm_nxt[g]), .carry(tm_en[g+1])
      );
    end
  endgenerate

  logic [7:0] hr_nxt;
  logic       day_c;
  cal_hours_step u_hours (.hr(q.hours), .en(tm_en[NTM]), .nxt(hr_nxt), .carry(day_c));

  logic [2:0] dow_nxt;
  logic       dow_c;
  cal_wrap_cnt #(.W(3), .LIMIT(3'd7), .START(3'd1)) u_dow (
    .val(q.day[2:0]), .en(day_c), .nxt(dow_nxt), .carry(dow_c)
  );

  logic [7:0] date_nxt;
  logic       date_hit, mon_en;
  always_comb begin
    date_hit = (q.date == last_date(q.month, q.year));
    mon_en   = day_c & date_hit;
    if (!day_c)        date_nxt = q.date;
    else if (date_hit) date_nxt = 8'h01;
    else               date_nxt = bcd_inc(q.date);
  end

  logic [7:0] mon_nxt, yr_nxt;
  logic       yr_en, yr_c;
  cal_wrap_cnt #(.W(8), .LIMIT(8'h12), .START(8'h01)) u_mon (
    .val(q.month), .en(mon_en), .nxt(mon_nxt), .carry(yr_en)
  );
  cal_wrap_cnt #(.W(8), .LIMIT(8'h99), .START(8'h00)) u_yr (
    .val(q.year), .en(yr_en), .nxt(yr_nxt), .carry(yr_c)
  );

  always_comb begin
    upd = load_en | step;
    if (load_en) begin
      d = cal_regs_t'(load_data & FIELD_MASK);
    end else begin
      d       = q;
      d.hund  = tm_nxt[0];
      d.secs  = tm_nxt[1];
      d.mins  = tm_nxt[2];
      d.hours = hr_nxt;
      d.day   = {q.day[7:3], dow_nxt};
      d.date  = date_nxt;
      d.month = mon_nxt;
      d.year  = yr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)  q <= cal_regs_t'(RESET_VAL);
    else if (upd) q <= d;
  end

  assign snap         = q;
  assign abort_pin_en = q.day[4];

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ((snap & ~FIELD_MASK) == '0));
  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    load_en |=> (snap == ($past(load_data) & FIELD_MASK)));
  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (q.day[5] && !load_en) |=> $stable(snap));
  // R4
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (step && q.hund == 8'h99) |=> (q.hund == 8'h00));
  // R7
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (day_c && !load_en && q.day[2:0] == 3'd7) |=> (q.day[2:0] == 3'd1));
  // R10
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (yr_c && !load_en) |=> (q.year == 8'h00 && q.month == 8'h01));
endmodule

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  localparam int TPS = 2;

  logic        clk = 1'b0;
  logic        rst_n, tick, load_en;
  logic [63:0] load_data;
  logic [63:0] snap;
  logic        abort_pin_en;

  always #5 clk = ~clk;

  bcd_calendar_core #(.TICKS_PER_STEP(TPS), .RST_SYNC_STAGES(2)) i_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
    .load_data(load_data), .snap(snap), .abort_pin_en(abort_pin_en)
  );

  int    vectors = 0, miscompares = 0;
  string req = "R1";

  int m_hund, m_sec, m_min, m_hr, m_pm, m_mode12, m_dow, m_stop, m_rsten;
  int m_date, m_mon, m_year, m_pcnt;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] pk(input logic [7:0] hu, se, mi, hr, dy, dt, mo, yr);
    return {yr, mo, dt, dy, hr, mi, se, hu};
  endfunction

  function automatic logic [63:0] expect_bus();
    logic [7:0] hb, db, t;
    t  = i2b(m_hr);
    hb = (m_mode12 != 0) ? {2'b10, 1'(m_pm), t[4:0]} : t;
    db = {2'b00, 1'(m_stop), 1'(m_rsten), 1'b0, 3'(m_dow)};
    return {i2b(m_year), i2b(m_mon), i2b(m_date), db, hb, i2b(m_min), i2b(m_sec), i2b(m_hund)};
  endfunction

  task automatic model_reset();
    m_hund = 0; m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_mode12 = 0;
    m_dow = 1; m_stop = 1; m_rsten = 1; m_date = 1; m_mon = 1; m_year = 0; m_pcnt = 0;
  endtask

  // R2: per-byte masks from the requirement
  task automatic model_load(input logic [63:0] raw);
    logic [63:0] v;
    v = raw & 64'hFF1F_3F37_BF7F_7FFF;
    m_hund = b2i(v[7:0]); m_sec = b2i(v[15:8]); m_min = b2i(v[23:16]);
    m_mode12 = int'(v[31]);
    if (v[31]) begin m_pm = int'(v[29]); m_hr = b2i({3'b000, v[28:24]}); end
    else begin m_pm = 0; m_hr = b2i({2'b00, v[29:24]}); end
    m_stop = int'(v[37]); m_rsten = int'(v[36]); m_dow = int'(v[34:32]);
    m_date = b2i(v[47:40]); m_mon = b2i(v[55:48]); m_year = b2i(v[63:56]);
    m_pcnt = 0;
  endtask

  task automatic model_advance();
    int dc;
    dc = 0;
    m_hund++;
    if (m_hund == 100) begin
      m_hund = 0; m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0;
          if (m_mode12 != 0) begin
            if (m_hr == 11) begin m_hr = 12; m_pm = 1 - m_pm; if (m_pm == 0) dc = 1; end
            else if (m_hr == 12) m_hr = 1;
            else m_hr++;
          end else begin
            m_hr++;
            if (m_hr == 24) begin m_hr = 0; dc = 1; end
          end
        end
      end
    end
    if (dc != 0) begin
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      if (m_date == mlen(m_mon, m_year)) begin
        m_date = 1; m_mon++;
        if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
      end else m_date++;
    end
  endtask

  task automatic model_clock(input logic t, input logic l, input logic [63:0] v);
    if (l) model_load(v);
    else if (t && m_stop == 0) begin
      m_pcnt++;
      if (m_pcnt == TPS) begin m_pcnt = 0; model_advance(); end
    end
  endtask

  task automatic check();
    logic [63:0] e;
    e = expect_bus();
    vectors++;
    if (snap !== e) begin
      miscompares++;
      $display("FAIL %s snap=%h expected=%h at %0t", req, snap, e, $time);
    end
    vectors++;
    if (abort_pin_en !== 1'(m_rsten)) begin
      miscompares++;
      $display("FAIL R12 abort_pin_en=%b expected=%0d at %0t", abort_pin_en, m_rsten, $time);
    end
  endtask

  task automatic cycle(input logic t, input logic l, input logic [63:0] v);
    tick = t; load_en = l; load_data = v;
    @(posedge clk);
    #1 model_clock(t, l, v);
    @(negedge clk);
    check();
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 64'h0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired, no end of test");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; tick = 1'b0; load_en = 1'b0; load_data = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    check();
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 64'h0);   // R1, R11: stopped after reset

    // R4 R5 R7 R10 R12: full rollover in 24-hour mode
    req = "R10";
    cycle(1'b0, 1'b1, pk(8'h98, 8'h59, 8'h59, 8'h23, 8'h17, 8'h31, 8'h12, 8'h99));
    run_ticks(6);

    // R4: seconds and minutes carries
    req = "R4";
    cycle(1'b0, 1'b1, pk(8'h97, 8'h09, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h05));
    run_ticks(10);

    // R5: every hour boundary in 24-hour mode
    req = "R5";
    for (int h = 0; h < 24; h++) begin
      cycle(1'b0, 1'b1, pk(8'h99, 8'h59, 8'h59, i2b(h), 8'h06, 8'h15, 8'h07, 8'h21));
      run_ticks(3);
    end

    // R6: every hour boundary in 12-hour mode, both halves of the day
    req = "R6";
    for (int p = 0; p < 2; p++) begin
      for (int h = 1; h <= 12; h++) begin
        logic [7:0] hb;
        hb = i2b(h);
        cycle(1'b0, 1'b1, pk(8'h99, 8'h59, 8'h59, {2'b10, 1'(p), hb[4:0]}, 8'h07, 8'h28, 8'h02, 8'h23));
        run_ticks(3);
      end
    end

    // R7: weekday wrap
    req = "R7";
    cycle(1'b0, 1'b1, pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h04, 8'h05, 8'h30));
    run_ticks(2);

    // R8: last day of every month in a common year
    req = "R8";
    for (int m = 1; m <= 12; m++) begin
      cycle(1'b0, 1'b1, pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, i2b(mlen(m, 23)), i2b(m), 8'h23));
      run_ticks(3);
    end

    // R9: February 28 and 29 across leap and common years
    req = "R9";
    foreach (lf[i]) begin end
    for (int k = 0; k < 10; k++) begin
      int yrs [10] = '{0, 4, 10, 12, 16, 18, 23, 24, 96, 98};
      cycle(1'b0, 1'b1, pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, i2b(yrs[k])));
      run_ticks(3);
      if (yrs[k] % 4 == 0) begin
        cycle(1'b0, 1'b1, pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, i2b(yrs[k])));
        run_ticks(3);
      end
    end

    // R11: stop bit freezes time, clearing it resumes
    req = "R11";
    cycle(1'b0, 1'b1, pk(8'h50, 8'h30, 8'h20, 8'h10, 8'h25, 8'h11, 8'h06, 8'h44));
    run_ticks(20);
    cycle(1'b0, 1'b1, pk(8'h50, 8'h30, 8'h20, 8'h10, 8'h05, 8'h11, 8'h06, 8'h44));
    run_ticks(8);

    // R3: load with a tick in the same cycle, mid-prescale
    req = "R3";
    cycle(1'b1, 1'b0, 64'h0);
    cycle(1'b1, 1'b1, pk(8'h10, 8'h00, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h01));
    run_ticks(5);

    // R2: write ones into read-as-zero bits
    req = "R2";
    cycle(1'b0, 1'b1, pk(8'h42, 8'hC5, 8'hB3, 8'hC3, 8'hDD, 8'hD5, 8'hE9, 8'h77));
    run_ticks(4);
    cycle(1'b0, 1'b1, pk(8'h42, 8'h80, 8'h80, 8'hF1, 8'hC8, 8'hC1, 8'hE1, 8'h00));
    run_ticks(4);

    // R13: sparse pseudo-random ticks, prescaler phase
    req = "R13";
    cycle(1'b0, 1'b1, pk(8'h00, 8'h50, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99));
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cycle(lf[0], 1'b0, 64'h0);
    end

    // R4 R6: long dense run in 12-hour mode
    req = "R6";
    cycle(1'b0, 1'b1, pk(8'h00, 8'h00, 8'h57, 8'hB1, 8'h13, 8'h31, 8'h12, 8'h99));
    run_ticks(40000);

    summary();
    $finish;
  end
endmodule